// File: doc/BRIEF.md
# Hardware Counting Semaphore

This block guards a shared resource that a bounded number of agents may use at once. It keeps a single slot counter and serves a fixed set of requesters. Each requester has its own request lines and can either take a slot (acquire) or hand one back (release). An acquire that finds a free slot is granted at once. An acquire that finds none parks the requester in a first-in, first-out wait list. The requester then stays stalled until a release passes the slot directly to it.

The counter's reset value is a parameter and is also the ceiling the counter may reach, so it sets how many holders may be inside the guarded region together. Every operation is a single-cycle read-modify-write of the counter. When several requesters ask in the same cycle, the block keeps the losers inside and applies one operation per cycle, lowest requester number first.

A release that would push the counter past its ceiling is discarded and leaves a sticky overflow flag. Misuse of the request lines raises a one-cycle error pulse, and the offending request is discarded. Two cases count as misuse: a second acquire from a requester that is already waiting, and any request from a requester whose previous request has not yet been applied.

Top module: `sem_unit`

## Requirements
- R1: After reset the counter equals the parameter SLOTS. The grant, waiting, overflow and protocol-error outputs are all zero.
- R2: An acquire (req_valid[i]=1 with req_is_v[i]=0) applied while the counter is above zero lowers the counter by one. It raises grant[i] for exactly the one cycle that follows the clock edge at which the operation is applied.
- R3: An acquire applied while the counter is zero gives no grant and leaves the counter at zero. It sets waiting[i], which stays set until the requester is served. The counter never goes below zero.
- R4: A release (req_valid[i]=1 with req_is_v[i]=1) applied while no requester waits and the counter is below SLOTS raises the counter by one and gives no grant.
- R5: A release applied while requesters wait leaves the counter unchanged. It raises a one-cycle grant to the requester that has waited longest and clears that requester's waiting bit. Waiters are served strictly in the order in which they were parked.
- R6: A release applied while no requester waits and the counter equals SLOTS is discarded. It sets the overflow output, which stays set until reset.
- R7: Operations arriving together are held inside the block and applied one per clock edge, lowest requester index first. A request that is not held back is applied at the edge where it is first sampled.
- R8: Two cases are misuse: an acquire from a requester whose waiting bit is set, and any request from a requester that still has an unapplied request held inside the block. Either one raises proto_err for one cycle and is discarded, without changing the counter, the wait list or the held requests.
- R9: The waiting vector is non-zero only while the counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Per-requester request strobe, one cycle per request |
| req_is_v | input | N_REQ | Per-requester operation: 0 acquire, 1 release |
| grant | output | N_REQ | One-cycle slot grant per requester |
| waiting | output | N_REQ | Requester is parked in the wait list |
| count | output | $clog2(SLOTS+1) | Current number of free slots |
| overflow | output | 1 | Sticky: a release found the counter already full |
| proto_err | output | 1 | One-cycle pulse for a discarded misuse request |

## Verification
A corrupted counter shows at the ports in the very next cycle. The count output can go out of range, a grant can appear while it reads zero, or waiters can coexist with a non-zero count. A damaged wait list shows only when a release arrives: the handoff grant lands on the wrong requester or on none. For that reason the bench drains every waiter it creates and checks each handoff target. A lost held request shows as a missing grant or waiting bit in the cycle its turn was due, so the bench checks every cycle of each simultaneous-request burst.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_TAKE,
    EV_PARK,
    EV_HANDOFF,
    EV_RETURN,
    EV_DROP
  } sem_ev_e;

  // Outcome of the operation that wins arbitration this cycle.
  function automatic sem_ev_e sem_decide(input logic valid, input logic is_v,
                                         input logic cnt_zero, input logic cnt_full,
                                         input logic q_empty);
    sem_ev_e ev;
    if (!valid)          ev = EV_NONE;
    else if (is_v) begin
      if (!q_empty)      ev = EV_HANDOFF;
      else if (cnt_full) ev = EV_DROP;
      else               ev = EV_RETURN;
    end
    else if (cnt_zero)   ev = EV_PARK;
    else                 ev = EV_TAKE;
    return ev;
  endfunction

endpackage

// File: rtl/sem_prio_arb.sv
module sem_prio_arb #(
  parameter int N   = 4,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   cand,
  output logic [N-1:0]   win_oh,
  output logic [IDW-1:0] win_idx,
  output logic           win_any
);
  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    win_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        win_oh  = '0;
        win_oh[i] = 1'b1;
        win_idx = IDW'(i);
        win_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sem_wait_fifo.sv
module sem_wait_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_id,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [OW-1:0] occ;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign head  = mem[rd_ptr];
  assign empty = (occ == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_id;
        wr_ptr      <= ptr_inc(wr_ptr);
      end
      if (pop) rd_ptr <= ptr_inc(rd_ptr);
      if (push && !pop)      occ <= occ + OW'(1);
      else if (pop && !push) occ <= occ - OW'(1);
    end
  end
endmodule

// File: rtl/sem_unit.sv
module sem_unit
  import sem_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int SLOTS = 2,
  localparam int IDW   = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_valid,
  input  logic [N_REQ-1:0] req_is_v,
  output logic [N_REQ-1:0] grant,
  output logic [N_REQ-1:0] waiting,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             proto_err
);
  logic [N_REQ-1:0] pend_q, pend_v_q, waiting_q, grant_q;
  logic [CNT_W-1:0] count_q;
  logic             ovf_q, perr_q;

  // Named internal events (also observed by the bound checker).
  logic [N_REQ-1:0] bad_req, new_ok, cand, cand_is_v, win_oh, head_oh;
  logic [IDW-1:0]   win_idx, q_head;
  logic             win_any, win_is_v, q_empty;
  sem_ev_e          ev;

  assign bad_req   = req_valid & (pend_q | (waiting_q & ~req_is_v));
  assign new_ok    = req_valid & ~bad_req;
  assign cand      = pend_q | new_ok;
  assign cand_is_v = (pend_q & pend_v_q) | (new_ok & req_is_v);

  sem_prio_arb #(.N(N_REQ)) u_arb (
    .cand    (cand),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .win_any (win_any)
  );

  assign win_is_v = |(win_oh & cand_is_v);
  assign ev = sem_decide(win_any, win_is_v, count_q == '0,
                         count_q == CNT_W'(SLOTS), q_empty);

  sem_wait_fifo #(.DEPTH(N_REQ), .W(IDW)) u_wq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (ev == EV_PARK),
    .push_id (win_idx),
    .pop     (ev == EV_HANDOFF),
    .head    (q_head),
    .empty   (q_empty)
  );

  always_comb begin
    head_oh = '0;
    head_oh[q_head] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      pend_v_q  <= '0;
      waiting_q <= '0;
      grant_q   <= '0;
      count_q   <= CNT_W'(SLOTS);
      ovf_q     <= 1'b0;
      perr_q    <= 1'b0;
    end else begin
      pend_q   <= cand & ~win_oh;
      pend_v_q <= cand_is_v & cand & ~win_oh;
      perr_q   <= |bad_req;
      grant_q  <= '0;
      unique case (ev)
        EV_TAKE: begin
          grant_q <= win_oh;
          count_q <= count_q - CNT_W'(1);
        end
        EV_PARK:    waiting_q <= waiting_q | win_oh;
        EV_HANDOFF: begin
          grant_q   <= head_oh;
          waiting_q <= waiting_q & ~head_oh;
        end
        EV_RETURN:  count_q <= count_q + CNT_W'(1);
        EV_DROP:    ovf_q   <= 1'b1;
        default: ;
      endcase
    end
  end

  assign grant     = grant_q;
  assign waiting   = waiting_q;
  assign count     = count_q;
  assign overflow  = ovf_q;
  assign proto_err = perr_q;
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk
  import sem_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int SLOTS = 2,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] grant,
  input logic [N_REQ-1:0] waiting,
  input logic [CNT_W-1:0] count,
  input logic             overflow,
  input sem_ev_e          ev
);
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(SLOTS));

  p_take_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_TAKE |=> count == $past(count) - CNT_W'(1) && $countones(grant) == 1);

  p_park_nogrant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_PARK |=> grant == '0 && count == '0);

  p_return_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_RETURN |=> count == $past(count) + CNT_W'(1) && grant == '0);

  p_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_HANDOFF |=> $countones(grant) == 1 && count == $past(count));

  p_no_grant_waiting_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & waiting) == '0);

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_DROP |=> overflow && $stable(count));

  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_wait_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    waiting != '0 |-> count == '0);
endmodule

bind sem_unit sem_unit_chk #(.N_REQ(N_REQ), .SLOTS(SLOTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .grant    (grant),
  .waiting  (waiting),
  .count    (count),
  .overflow (overflow),
  .ev       (ev)
);

// File: tb/test_sem_unit.sv
module test_sem_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int SLOTS = 2;
  localparam int CW    = $clog2(SLOTS + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_valid = '0, req_is_v = '0;
  logic [N-1:0]  grant, waiting;
  logic [CW-1:0] count;
  logic          overflow, proto_err;
  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sem_unit #(.N_REQ(N), .SLOTS(SLOTS)) i_sem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_v(req_is_v),
    .grant(grant), .waiting(waiting), .count(count),
    .overflow(overflow), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = '0; req_is_v = '0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(count == CW'(SLOTS), "R1 count", count, SLOTS);
    chk(grant == '0 && waiting == '0, "R1 grant/waiting", {grant, waiting}, 0);
    chk(!overflow && !proto_err, "R1 flags", {overflow, proto_err}, 0);
  endtask

  // One request cycle: drive at a falling edge, sample at the next one.
  task automatic send(input logic [N-1:0] p, input logic [N-1:0] v);
    req_valid = p | v; req_is_v = v;
    @(negedge clk);
    req_valid = '0; req_is_v = '0;
  endtask

  initial begin
    int order[N];
    int n, cnt;
    logic [N-1:0] exp_wait;
    @(negedge clk);
    // Sweep every non-empty set of simultaneous acquires.
    for (int m = 1; m < (1 << N); m++) begin
      do_reset();
      n = 0;
      for (int id = 0; id < N; id++) if (m[id]) begin order[n] = id; n++; end
      req_valid = N'(m); req_is_v = '0;
      exp_wait = '0;
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        req_valid = '0;
        if (k < SLOTS) begin
          chk(grant == N'(1 << order[k]), "R7 order/R2 grant", grant, 1 << order[k]);
          chk(count == CW'(SLOTS - k - 1), "R2 count", count, SLOTS - k - 1);
        end else begin
          exp_wait[order[k]] = 1'b1;
          chk(grant == '0, "R3 no grant", grant, 0);
          chk(count == '0, "R3 count", count, 0);
        end
      end
      chk(waiting == exp_wait, "R3 waiting", waiting, exp_wait);
      if (exp_wait != '0) chk(count == '0, "R9 zero while waiting", count, 0);
      // Drain waiters in parking order.
      for (int k = SLOTS; k < n; k++) begin
        send(N'(1 << order[0]), N'(1 << order[0]));
        send('0, '0); // keep releases one per request cycle
        exp_wait[order[k]] = 1'b0;
      end
      if (n > SLOTS) chk(waiting == '0, "R5 drained", waiting, 0);
      cnt = (n >= SLOTS) ? 0 : SLOTS - n;
      while (cnt < SLOTS) begin
        send('0, 4'b0001);
        cnt++;
        chk(count == CW'(cnt), "R4 count up", count, cnt);
        chk(grant == '0 && !overflow, "R4 no grant", grant, 0);
      end
      send('0, 4'b0001);
      chk(overflow, "R6 overflow set", overflow, 1);
      chk(count == CW'(SLOTS), "R6 count held", count, SLOTS);
      @(negedge clk);
      chk(overflow, "R6 sticky", overflow, 1);
    end

    // Handoff order checked cycle by cycle: 0,1 hold, 3 then 2 park.
    do_reset();
    send(4'b0001, '0); send(4'b0010, '0);
    send(4'b1000, '0); send(4'b0100, '0);
    chk(waiting == 4'b1100, "R3 two waiters", waiting, 4'b1100);
    send('0, 4'b0001);
    chk(grant == 4'b1000, "R5 oldest first", grant, 4'b1000);
    chk(count == '0, "R5 count kept", count, 0);
    @(negedge clk);
    chk(grant == '0, "R5 one-cycle grant", grant, 0);
    send('0, 4'b0010);
    chk(grant == 4'b0100 && waiting == '0, "R5 second waiter", grant, 4'b0100);

    // Mixed same-cycle acquire and release: lower index (acquire) first.
    do_reset();
    send(4'b0001, '0); send(4'b0010, '0);
    send(4'b0100, 4'b1000);
    chk(waiting == 4'b0100 && grant == '0, "R7 acquire applied first", waiting, 4'b0100);
    @(negedge clk);
    chk(grant == 4'b0100 && waiting == '0, "R7 held release hands off", grant, 4'b0100);

    // Misuse while held, then repeated acquire while waiting.
    do_reset();
    req_valid = 4'b0111; req_is_v = '0;
    @(negedge clk);
    chk(grant == 4'b0001, "R7 first of three", grant, 1);
    req_valid = 4'b0100; req_is_v = 4'b0100;
    @(negedge clk);
    req_valid = '0; req_is_v = '0;
    chk(proto_err, "R8 request while held", proto_err, 1);
    chk(grant == 4'b0010, "R7 second of three", grant, 2);
    @(negedge clk);
    chk(!proto_err && waiting == 4'b0100, "R8 held acquire kept", waiting, 4'b0100);
    send(4'b0100, '0);
    chk(proto_err, "R8 acquire while waiting", proto_err, 1);
    chk(waiting == 4'b0100 && count == '0, "R8 state unchanged", waiting, 4'b0100);
    send('0, 4'b0001);
    chk(grant == 4'b0100 && !proto_err, "R8 single handoff", grant, 4'b0100);
    send('0, 4'b0010);
    chk(count == CW'(1) && grant == '0, "R8 no duplicate entry", count, 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule